// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block picks the two ALU operands for the instruction now in the execute stage of a five-stage in-order integer pipeline. For each source index of that instruction it compares against the destination indices held in the two pipeline registers after execute. The ALU-output register is one stage behind execute, and the write-back register is two stages behind. When a match is found, the newer result is steered onto the operand in place of the stale register-file value.

The block has no storage and no clock. Only two bypass paths are needed because the register file completes a write-back before it is read in decode in the same cycle. An instruction three places after the producer therefore already reads the correct value from the register file. Results enter the register file only at write-back.

A value loaded from memory is not available early enough for the instruction right after the load. That hazard belongs to a separate stall unit and is not handled here.

Top module: `operand_bypass_sel`

## Requirements
- R1: With both later-stage write enables low, each select output is 2'b00 and each operand equals its register-file input.
- R2: When the ALU-output stage writes a non-zero destination equal to a source index, that operand's select is 2'b10 and the operand equals `alu_stage_result`.
- R3: When only the write-back stage writes a non-zero destination equal to a source index, that operand's select is 2'b01 and the operand equals `wb_stage_value`.
- R4: When both stages write the same non-zero destination and it equals a source index, the ALU-output stage wins, giving select 2'b10.
- R5: A source or destination index of zero is never bypassed. The operand then equals the register-file input with select 2'b00, whatever the enables are.
- R6: A stage whose write enable is low has no effect, even when its destination matches.
- R7: The two operands are resolved independently. Operand A follows `src_a_idx` and operand B follows `src_b_idx`, and the select code 2'b11 never appears.
- R8: In a dependent ALU instruction sequence, every operand equals the value held in a reference register model after all older instructions. This holds for consumers one, two and three or more places behind the producer, given that the register file writes before it reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a_idx | input | IDX_W | First source register index of the executing instruction |
| src_b_idx | input | IDX_W | Second source register index of the executing instruction |
| alu_stage_dst | input | IDX_W | Destination index held in the ALU-output pipeline register |
| alu_stage_wen | input | 1 | Register write enable held in the ALU-output pipeline register |
| alu_stage_result | input | DATA_W | ALU result held in the ALU-output pipeline register |
| wb_stage_dst | input | IDX_W | Destination index held in the write-back pipeline register |
| wb_stage_wen | input | 1 | Register write enable held in the write-back pipeline register |
| wb_stage_value | input | DATA_W | Value about to be written back |
| rf_a_value | input | DATA_W | Register-file read value for the first source |
| rf_b_value | input | DATA_W | Register-file read value for the second source |
| sel_a | output | 2 | Bypass select for operand A (00 file, 10 ALU stage, 01 write-back) |
| sel_b | output | 2 | Bypass select for operand B (00 file, 10 ALU stage, 01 write-back) |
| operand_a | output | DATA_W | Selected value for operand A |
| operand_b | output | DATA_W | Selected value for operand B |

## Verification
The bench sweeps every combination of eight index values for each source and each destination, over all four write-enable pairs. The eight values include zero and the top index 31. This separates a match in one stage from a match in both, tells an enabled match from a disabled one, and separates register zero from real registers. Each index pattern is tried on both operands together, so it also shows whether a match on one operand leaks into the other.

A scripted dependent sequence is then run against a reference register model. It places consumers one, two and three places behind a producer, and it includes writes to register zero. This shows that the two bypass paths and the register file's write-before-read cover every distance.

// File: rtl/operand_bypass_sel.sv
module operand_bypass_sel #(
  parameter int IDX_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic [IDX_W-1:0]  src_a_idx,
  input  logic [IDX_W-1:0]  src_b_idx,
  input  logic [IDX_W-1:0]  alu_stage_dst,
  input  logic              alu_stage_wen,
  input  logic [DATA_W-1:0] alu_stage_result,
  input  logic [IDX_W-1:0]  wb_stage_dst,
  input  logic              wb_stage_wen,
  input  logic [DATA_W-1:0] wb_stage_value,
  input  logic [DATA_W-1:0] rf_a_value,
  input  logic [DATA_W-1:0] rf_b_value,
  output logic [1:0]        sel_a,
  output logic [1:0]        sel_b,
  output logic [DATA_W-1:0] operand_a,
  output logic [DATA_W-1:0] operand_b
);
  localparam logic [1:0] SEL_FILE = 2'b00;
  localparam logic [1:0] SEL_ALU  = 2'b10;
  localparam logic [1:0] SEL_WB   = 2'b01;

  logic alu_live, wb_live;
  assign alu_live = alu_stage_wen && (alu_stage_dst != '0);
  assign wb_live  = wb_stage_wen  && (wb_stage_dst  != '0);

  function automatic logic [1:0] pick(input logic [IDX_W-1:0] src);
    if (alu_live && alu_stage_dst == src)   return SEL_ALU;
    else if (wb_live && wb_stage_dst == src) return SEL_WB;
    else                                     return SEL_FILE;
  endfunction

  function automatic logic [DATA_W-1:0] steer(input logic [1:0] s,
                                               input logic [DATA_W-1:0] file_v);
    case (s)
      SEL_ALU: return alu_stage_result;
      SEL_WB:  return wb_stage_value;
      default: return file_v;
    endcase
  endfunction

  assign sel_a     = pick(src_a_idx);
  assign sel_b     = pick(src_b_idx);
  assign operand_a = steer(sel_a, rf_a_value);
  assign operand_b = steer(sel_b, rf_b_value);
endmodule

// File: rtl/operand_bypass_sel_checker.sv
module operand_bypass_sel_checker #(
  parameter int IDX_W  = 5,
  parameter int DATA_W = 32
) (
  input logic [IDX_W-1:0]  src_a_idx,
  input logic [IDX_W-1:0]  src_b_idx,
  input logic [IDX_W-1:0]  alu_stage_dst,
  input logic              alu_stage_wen,
  input logic [DATA_W-1:0] alu_stage_result,
  input logic [IDX_W-1:0]  wb_stage_dst,
  input logic              wb_stage_wen,
  input logic [DATA_W-1:0] wb_stage_value,
  input logic [DATA_W-1:0] rf_a_value,
  input logic [DATA_W-1:0] rf_b_value,
  input logic [1:0]        sel_a,
  input logic [1:0]        sel_b,
  input logic [DATA_W-1:0] operand_a,
  input logic [DATA_W-1:0] operand_b
);
  logic known;
  assign known = !$isunknown({src_a_idx, src_b_idx, alu_stage_dst, alu_stage_wen,
                              wb_stage_dst, wb_stage_wen, sel_a, sel_b});

  always_comb begin
    if (known) begin
      assert_no_enable_file_R1: assert (alu_stage_wen || wb_stage_wen || (sel_a == 2'b00 && sel_b == 2'b00));
      assert_alu_value_R2: assert (sel_a != 2'b10 || operand_a == alu_stage_result);
      assert_wb_value_R3: assert (sel_b != 2'b01 || operand_b == wb_stage_value);
      assert_alu_wins_R4: assert (!(alu_stage_wen && alu_stage_dst == src_a_idx && src_a_idx != '0) || sel_a == 2'b10);
      assert_zero_idx_R5: assert (src_a_idx != '0 || (sel_a == 2'b00 && operand_a == rf_a_value));
      assert_wen_low_R6: assert (alu_stage_wen || sel_b != 2'b10);
      assert_code_legal_R7: assert ($countones(sel_a) <= 1 && $countones(sel_b) <= 1);
    end
  end
endmodule

bind operand_bypass_sel operand_bypass_sel_checker #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/operand_bypass_sel_bench.sv
`timescale 1ns/1ps
module operand_bypass_sel_bench;
  localparam int IW = 5;
  localparam int DW = 32;

  logic clk = 0;
  always #10 clk = ~clk;

  logic [IW-1:0] sa, sb, ad, wd;
  logic          aw, ww;
  logic [DW-1:0] ar, wv, fa, fb;
  logic [1:0]    sel_a, sel_b;
  logic [DW-1:0] op_a, op_b;

  operand_bypass_sel u_operand_bypass_sel (
    .src_a_idx(sa), .src_b_idx(sb), .alu_stage_dst(ad), .alu_stage_wen(aw),
    .alu_stage_result(ar), .wb_stage_dst(wd), .wb_stage_wen(ww), .wb_stage_value(wv),
    .rf_a_value(fa), .rf_b_value(fb), .sel_a(sel_a), .sel_b(sel_b),
    .operand_a(op_a), .operand_b(op_b));

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [IW-1:0] idx(input int k);
    case (k)
      4: return 5'd15;
      5: return 5'd16;
      6: return 5'd30;
      7: return 5'd31;
      default: return k[IW-1:0];
    endcase
  endfunction

  function automatic logic [1:0] exp_sel(input logic [IW-1:0] s);
    if (aw && ad != 0 && ad == s) return 2'b10;
    if (ww && wd != 0 && wd == s) return 2'b01;
    return 2'b00;
  endfunction

  function automatic string tag(input logic [1:0] e, input logic [IW-1:0] s);
    if (s == 0) return "R5";
    if (e == 2'b10) return (ww && wd == s) ? "R4" : "R2";
    if (e == 2'b01) return "R3";
    if (!aw && !ww) return "R1";
    return "R6";
  endfunction

  logic [DW-1:0] arch [32];
  logic [DW-1:0] rfile [32];
  logic [IW-1:0] p_dst [16];
  logic [IW-1:0] p_sa [16];
  logic [IW-1:0] p_sb [16];
  logic [DW-1:0] p_res [16];

  initial begin
    ar = 32'hA1A1_0000; wv = 32'hB2B2_0000; fa = 32'hCAFE_000A; fb = 32'hCAFE_000B;
    sa = 0; sb = 0; ad = 0; wd = 0; aw = 0; ww = 0;
    #5;
    chk("R1 idle sel_a", {30'd0, sel_a}, 0);
    chk("R1 idle op_b", op_b, fb);

    for (int w = 0; w < 4; w++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          for (int k = 0; k < 8; k++)
            for (int m = 0; m < 8; m++) begin
              logic [1:0] ea, eb;
              aw = w[0]; ww = w[1];
              sa = idx(i); sb = idx(j); ad = idx(k); wd = idx(m);
              ar = 32'hA1A1_0000 + 32'(k); wv = 32'hB2B2_0000 + 32'(m);
              #1;
              ea = exp_sel(sa); eb = exp_sel(sb);
              chk({tag(ea, sa), " R7 sel_a"}, {30'd0, sel_a}, {30'd0, ea});
              chk({tag(eb, sb), " R7 sel_b"}, {30'd0, sel_b}, {30'd0, eb});
              chk({tag(ea, sa), " op_a"}, op_a, ea == 2'b10 ? ar : ea == 2'b01 ? wv : fa);
              chk({tag(eb, sb), " op_b"}, op_b, eb == 2'b10 ? ar : eb == 2'b01 ? wv : fb);
              #1;
            end

    // R8 scripted dependent sequence
    for (int r = 0; r < 32; r++) begin arch[r] = 32'(r * 3); rfile[r] = 32'(r * 3); end
    p_dst = '{5'd2, 5'd12, 5'd13, 5'd14, 5'd0, 5'd2, 5'd2, 5'd7, 5'd0, 5'd9, 5'd9, 5'd4, 5'd31, 5'd31, 5'd1, 5'd2};
    p_sa  = '{5'd1, 5'd2, 5'd6, 5'd2, 5'd14, 5'd0, 5'd2, 5'd2, 5'd7, 5'd0, 5'd9, 5'd9, 5'd4, 5'd31, 5'd31, 5'd2};
    p_sb  = '{5'd3, 5'd5, 5'd2, 5'd2, 5'd2, 5'd0, 5'd2, 5'd0, 5'd7, 5'd8, 5'd2, 5'd31, 5'd9, 5'd31, 5'd0, 5'd1};
    for (int n = 0; n < 16; n++) begin
      if (n >= 3 && p_dst[n-3] != 0) rfile[p_dst[n-3]] = p_res[n-3];
      sa = p_sa[n]; sb = p_sb[n];
      fa = rfile[sa]; fb = rfile[sb];
      aw = n >= 1; ad = n >= 1 ? p_dst[n-1] : 5'd0; ar = n >= 1 ? p_res[n-1] : '0;
      ww = n >= 2; wd = n >= 2 ? p_dst[n-2] : 5'd0; wv = n >= 2 ? p_res[n-2] : '0;
      @(negedge clk);
      chk($sformatf("R8 seq %0d op_a", n), op_a, arch[sa]);
      chk($sformatf("R8 seq %0d op_b", n), op_b, arch[sb]);
      p_res[n] = arch[sa] + arch[sb] + 32'(n * 16 + 1);
      if (p_dst[n] != 0) arch[p_dst[n]] = p_res[n];
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule